// File: doc/BRIEF.md
# Event-Triggered Four-Channel DMA Controller

This block copies data from one address to another on a simple synchronous memory bus. It has four channels, and each channel has its own source pointer, destination pointer, element count and control word. A channel starts in one of two ways. It can start as soon as its control word is written. It can also wait for one of three outside events: a vertical-blank pulse, a horizontal-blank pulse or a sound-FIFO request. Each channel has one pending bit. One transfer engine serves the pending channels one after another, and while any bit is set the block holds the processor in a stall.

Each element costs three cycles. In the first cycle the engine reads the source. In the second it captures the returned data. In the third it writes that data to the destination. Channels 1 and 2 have a FIFO mode. In this mode a request moves a burst of four 32-bit words into a fixed destination, and the programmed count is ignored. Bus addresses are always aligned to the element size, but the internal pointers keep their low bits. When a channel completes, it can raise a one-cycle interrupt pulse.

The register write port selects a channel and a byte offset within that channel. Offset 0 holds the source pointer and offset 4 the destination pointer. Offset 8 holds the count (the low CW bits) and offset 10 the control word (bits 15:0 of the write data). The internal copies of the source and destination pointers are loaded when the enable bit goes from 0 to 1.

Top module: `dmac_top`

## Requirements
- R1: A control write (offset 10) with enable (bit 15) set and timing code (bits 13:12) equal to 0 makes the channel pending. The first bus read appears one cycle after the write edge.
- R2: Any other control write clears the channel's pending bit, which cancels an event that is still queued.
- R3: A vblank_i pulse makes every enabled channel with timing code 1 pending. An hblank_i pulse does the same for timing code 2. Channels with other codes do not react.
- R4: A fifo_req_i pulse makes a channel pending only if all of these hold: the channel is 1 or 2, it is enabled, its timing code is 3, and its programmed destination equals fifo_addr_i.
- R5: In FIFO mode the block moves exactly four 32-bit words whatever the count. The source advances by 4 after each word and the destination stays fixed.
- R6: Control bit 10 selects the element size: 1 for 32-bit, 0 for 16-bit. The pointer step is 4 or 2. A 32-bit access puts 0 on address bits 1:0, and a 16-bit access puts 0 on address bit 0.
- R7: Bits 8:7 set how the source moves and bits 6:5 set how the destination moves: 0 increments, 1 decrements, 2 or 3 holds.
- R8: A count of 0 means 2^CW elements.
- R9: When several channels are pending, they are served in ascending channel order.
- R10: cpu_stall_o is high exactly while at least one pending bit is set. It is low out of reset.
- R11: A completion with repeat (bit 9) clear turns the enable bit off, so later events do nothing. With repeat set the channel stays enabled, and the next event restarts it from the pointers where the last run ended.
- R12: When interrupt enable (bit 14) is set, completion raises irq_o[channel] for one cycle, 3n+1 cycles after the starting edge for n elements. No pulse is raised when the bit is clear.
- R13: Each element reads the source, then writes the data it read two cycles later. A read and a write never happen in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_ch_i | input | 2 | Channel selected by the write |
| cfg_ofs_i | input | 4 | Register offset (0, 4, 8, 10) |
| cfg_wdata_i | input | 32 | Register write data |
| vblank_i | input | 1 | Vertical-blank event pulse |
| hblank_i | input | 1 | Horizontal-blank event pulse |
| fifo_req_i | input | 1 | Sound-FIFO request pulse |
| fifo_addr_i | input | AW | Address of the requesting FIFO |
| mem_rd_o | output | 1 | Bus read strobe |
| mem_wr_o | output | 1 | Bus write strobe |
| mem_size32_o | output | 1 | 1: 32-bit access, 0: 16-bit access |
| mem_addr_o | output | AW | Aligned bus address |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, valid the cycle after mem_rd_o |
| cpu_stall_o | output | 1 | Processor stall |
| irq_o | output | 4 | Per-channel completion pulse |

## Verification
Suppose a start write lands on edge E0. The pending bit and the stall appear right after E0, and the first read strobe appears after E1. Element k is written after edge E3+3k, and the interrupt pulse lies between E(3n+1) and E(3n+2). At E(3n+2) the pending bit drops, and the stall drops with it. The bench samples at the falling edge and counts falling edges from the start write. This lets it compare these exact cycle numbers, including the one-cycle width of the pulse. For the event, order and FIFO scenarios it waits for the stall to drop. It then checks the memory model's contents and its log of bus addresses against values worked out from the initial memory pattern.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  localparam int NCH = 4;
  localparam int CHW = 2;

  typedef enum logic [1:0] {TM_NOW = 2'd0, TM_VBL = 2'd1, TM_HBL = 2'd2, TM_FIFO = 2'd3} dma_tm_e;
  typedef enum logic [1:0] {AC_INC = 2'd0, AC_DEC = 2'd1, AC_HOLD = 2'd2, AC_HOLD2 = 2'd3} dma_ac_e;

  typedef struct packed {
    logic    en;
    logic    irq_en;
    dma_tm_e tm;
    logic    rsv_a;
    logic    w32;
    logic    rpt;
    dma_ac_e sac;
    dma_ac_e dac;
    logic [4:0] rsv_b;
  } dma_ctrl_t;

  localparam logic [3:0] OFS_SRC = 4'd0;
  localparam logic [3:0] OFS_DST = 4'd4;
  localparam logic [3:0] OFS_CNT = 4'd8;
  localparam logic [3:0] OFS_CTL = 4'd10;
endpackage

// File: rtl/dmac_arb.sv
module dmac_arb #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  req_i,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
    any_o = |req_i;
  end
endmodule

// File: rtl/dmac_chan.sv
module dmac_chan
  import dmac_pkg::*;
#(
  parameter int CH_ID = 0,
  parameter int AW    = 32,
  parameter int CW    = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en_i,
  input  logic [3:0]    wr_ofs_i,
  input  logic [31:0]   wr_data_i,
  input  logic          vblank_i,
  input  logic          hblank_i,
  input  logic          fifo_req_i,
  input  logic [AW-1:0] fifo_addr_i,
  input  logic          fin_i,
  input  logic [AW-1:0] fin_src_i,
  input  logic [AW-1:0] fin_dst_i,
  output dma_ctrl_t     ctrl_o,
  output logic [CW-1:0] cnt_o,
  output logic [AW-1:0] src_o,
  output logic [AW-1:0] dst_o,
  output logic          pend_o
);
  localparam bit FIFO_OK = (CH_ID == 1) || (CH_ID == 2);

  logic [AW-1:0] src_reg, dst_reg;
  logic          running;
  dma_ctrl_t     wr_ctrl;
  logic          ctrl_wr, trig;

  assign wr_ctrl = dma_ctrl_t'(wr_data_i[15:0]);
  assign ctrl_wr = wr_en_i && (wr_ofs_i == OFS_CTL);

  always_comb begin
    trig = 1'b0;
    if (ctrl_o.en) begin
      if (vblank_i && ctrl_o.tm == TM_VBL) trig = 1'b1;
      if (hblank_i && ctrl_o.tm == TM_HBL) trig = 1'b1;
      if (FIFO_OK && running && fifo_req_i && ctrl_o.tm == TM_FIFO && dst_reg == fifo_addr_i)
        trig = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      src_reg <= '0;
      dst_reg <= '0;
      src_o   <= '0;
      dst_o   <= '0;
      cnt_o   <= '0;
      ctrl_o  <= '0;
      running <= 1'b0;
      pend_o  <= 1'b0;
    end else begin
      if (fin_i) begin
        src_o <= fin_src_i;
        dst_o <= fin_dst_i;
        if (!ctrl_o.rpt) begin
          ctrl_o.en <= 1'b0;
          running   <= 1'b0;
        end
      end
      if (ctrl_wr)   pend_o <= wr_ctrl.en && (wr_ctrl.tm == TM_NOW);
      else if (trig) pend_o <= 1'b1;
      else if (fin_i) pend_o <= 1'b0;
      if (wr_en_i) begin
        case (wr_ofs_i)
          OFS_SRC: src_reg <= wr_data_i[AW-1:0];
          OFS_DST: dst_reg <= wr_data_i[AW-1:0];
          OFS_CNT: cnt_o   <= wr_data_i[CW-1:0];
          OFS_CTL: begin
            ctrl_o  <= wr_ctrl;
            running <= wr_ctrl.en;
            if (wr_ctrl.en && !ctrl_o.en) begin
              src_o <= src_reg;
              dst_o <= dst_reg;
            end
          end
          default: ;
        endcase
      end
    end
  end

  p_start_pend_r1: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && wr_ctrl.en && wr_ctrl.tm == TM_NOW) |=> pend_o);
  p_ctrl_clear_r2: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && !(wr_ctrl.en && wr_ctrl.tm == TM_NOW)) |=> !pend_o);
  p_no_stray_pend_r4: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_wr && !pend_o && !vblank_i && !hblank_i &&
     !(FIFO_OK && fifo_req_i && fifo_addr_i == dst_reg)) |=> !pend_o);
  p_done_disables_r11: assert property (@(posedge clk) disable iff (rst)
    (fin_i && !ctrl_o.rpt && !ctrl_wr) |=> !ctrl_o.en);
endmodule

// File: rtl/dmac_xfer.sv
module dmac_xfer
  import dmac_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NCH-1:0]          pend_i,
  input  dma_ctrl_t [NCH-1:0]     ctrl_i,
  input  logic [NCH-1:0][CW-1:0]  cnt_i,
  input  logic [NCH-1:0][AW-1:0]  src_i,
  input  logic [NCH-1:0][AW-1:0]  dst_i,
  input  logic [31:0]             mem_rdata_i,
  output logic                    mem_rd_o,
  output logic                    mem_wr_o,
  output logic                    mem_size32_o,
  output logic [AW-1:0]           mem_addr_o,
  output logic [31:0]             mem_wdata_o,
  output logic                    fin_o,
  output logic [CHW-1:0]          fin_ch_o,
  output logic [AW-1:0]           fin_src_o,
  output logic [AW-1:0]           fin_dst_o,
  output logic [NCH-1:0]          irq_o
);
  typedef enum logic [2:0] {S_IDLE, S_RD, S_CAP, S_WR, S_FIN} xstate_e;

  xstate_e        state;
  logic [CHW-1:0] ch, sel;
  logic           any;
  logic [AW-1:0]  cur_src, cur_dst, nsrc, ndst, step;
  logic [CW:0]    left;
  logic           w32, fifo, irq_en;
  dma_ac_e        sac, dac;
  logic           sel_fifo;

  dmac_arb #(.N(NCH), .IW(CHW)) arb_i (.req_i(pend_i), .idx_o(sel), .any_o(any));

  function automatic logic [AW-1:0] adj(input logic [AW-1:0] a, input dma_ac_e ac,
                                        input logic [AW-1:0] st);
    case (ac)
      AC_INC:  return a + st;
      AC_DEC:  return a - st;
      default: return a;
    endcase
  endfunction

  function automatic logic [AW-1:0] algn(input logic [AW-1:0] a, input logic wide);
    return wide ? {a[AW-1:2], 2'b00} : {a[AW-1:1], 1'b0};
  endfunction

  assign sel_fifo = (ctrl_i[sel].tm == TM_FIFO) && (sel == CHW'(1) || sel == CHW'(2));
  assign step     = w32 ? AW'(4) : AW'(2);
  assign nsrc     = fifo ? cur_src + AW'(4) : adj(cur_src, sac, step);
  assign ndst     = fifo ? cur_dst : adj(cur_dst, dac, step);

  assign fin_o     = (state == S_FIN);
  assign fin_ch_o  = ch;
  assign fin_src_o = cur_src;
  assign fin_dst_o = cur_dst;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;
      ch <= '0; cur_src <= '0; cur_dst <= '0; left <= '0;
      w32 <= 1'b0; fifo <= 1'b0; irq_en <= 1'b0; sac <= AC_INC; dac <= AC_INC;
      mem_rd_o <= 1'b0; mem_wr_o <= 1'b0; mem_size32_o <= 1'b0;
      mem_addr_o <= '0; mem_wdata_o <= '0; irq_o <= '0;
    end else begin
      irq_o <= '0;
      case (state)
        S_IDLE: if (any) begin
          ch      <= sel;
          cur_src <= src_i[sel];
          cur_dst <= dst_i[sel];
          fifo    <= sel_fifo;
          w32     <= sel_fifo || ctrl_i[sel].w32;
          sac     <= ctrl_i[sel].sac;
          dac     <= ctrl_i[sel].dac;
          irq_en  <= ctrl_i[sel].irq_en;
          if (sel_fifo)             left <= (CW+1)'(4);
          else if (cnt_i[sel] == '0) left <= {1'b1, {CW{1'b0}}};
          else                      left <= {1'b0, cnt_i[sel]};
          mem_rd_o     <= 1'b1;
          mem_size32_o <= sel_fifo || ctrl_i[sel].w32;
          mem_addr_o   <= algn(src_i[sel], sel_fifo || ctrl_i[sel].w32);
          state        <= S_RD;
        end
        S_RD: begin
          mem_rd_o <= 1'b0;
          state    <= S_CAP;
        end
        S_CAP: begin
          mem_wr_o    <= 1'b1;
          mem_addr_o  <= algn(cur_dst, w32);
          mem_wdata_o <= mem_rdata_i;
          state       <= S_WR;
        end
        S_WR: begin
          mem_wr_o <= 1'b0;
          cur_src  <= nsrc;
          cur_dst  <= ndst;
          left     <= left - 1'b1;
          if (left == (CW+1)'(1)) begin
            irq_o[ch] <= irq_en;
            state     <= S_FIN;
          end else begin
            mem_rd_o   <= 1'b1;
            mem_addr_o <= algn(nsrc, w32);
            state      <= S_RD;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  p_irq_onehot_r12: assert property (@(posedge clk) disable iff (rst) $onehot0(irq_o));
  p_irq_pulse_r12: assert property (@(posedge clk) disable iff (rst)
    (|irq_o) |=> (irq_o == '0));
  p_rdwr_excl_r13: assert property (@(posedge clk) disable iff (rst) !(mem_rd_o && mem_wr_o));
  p_bus_align_r6: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_o || mem_wr_o) |-> (mem_size32_o ? (mem_addr_o[1:0] == 2'b00) : !mem_addr_o[0]));
endmodule

// File: rtl/dmac_top.sv
module dmac_top
  import dmac_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we_i,
  input  logic [1:0]    cfg_ch_i,
  input  logic [3:0]    cfg_ofs_i,
  input  logic [31:0]   cfg_wdata_i,
  input  logic          vblank_i,
  input  logic          hblank_i,
  input  logic          fifo_req_i,
  input  logic [AW-1:0] fifo_addr_i,
  output logic          mem_rd_o,
  output logic          mem_wr_o,
  output logic          mem_size32_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [31:0]   mem_wdata_o,
  input  logic [31:0]   mem_rdata_i,
  output logic          cpu_stall_o,
  output logic [3:0]    irq_o
);
  dma_ctrl_t [NCH-1:0]    ctrl_a;
  logic [NCH-1:0][CW-1:0] cnt_a;
  logic [NCH-1:0][AW-1:0] src_a, dst_a;
  logic [NCH-1:0]         pend_a;
  logic                   fin;
  logic [CHW-1:0]         fin_ch;
  logic [AW-1:0]          fin_src, fin_dst;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    dmac_chan #(.CH_ID(g), .AW(AW), .CW(CW)) chan_i (
      .clk(clk), .rst(rst),
      .wr_en_i(cfg_we_i && cfg_ch_i == CHW'(g)),
      .wr_ofs_i(cfg_ofs_i), .wr_data_i(cfg_wdata_i),
      .vblank_i(vblank_i), .hblank_i(hblank_i),
      .fifo_req_i(fifo_req_i), .fifo_addr_i(fifo_addr_i),
      .fin_i(fin && fin_ch == CHW'(g)), .fin_src_i(fin_src), .fin_dst_i(fin_dst),
      .ctrl_o(ctrl_a[g]), .cnt_o(cnt_a[g]), .src_o(src_a[g]), .dst_o(dst_a[g]),
      .pend_o(pend_a[g]));
  end

  dmac_xfer #(.AW(AW), .CW(CW)) xfer_i (
    .clk(clk), .rst(rst), .pend_i(pend_a), .ctrl_i(ctrl_a), .cnt_i(cnt_a),
    .src_i(src_a), .dst_i(dst_a), .mem_rdata_i(mem_rdata_i),
    .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o), .mem_size32_o(mem_size32_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .fin_o(fin), .fin_ch_o(fin_ch), .fin_src_o(fin_src), .fin_dst_o(fin_dst),
    .irq_o(irq_o));

  assign cpu_stall_o = |pend_a;
endmodule

// File: tb/dmac_top_tb_top.sv
module dmac_top_tb_top;
  localparam int AW = 32;
  localparam int CW = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_ch = '0;
  logic [3:0] cfg_ofs = '0;
  logic [31:0] cfg_wdata = '0;
  logic vblank = 1'b0, hblank = 1'b0, fifo_req = 1'b0;
  logic [AW-1:0] fifo_addr = '0;
  logic mem_rd_o, mem_wr_o, mem_size32_o, cpu_stall_o;
  logic [AW-1:0] mem_addr_o;
  logic [31:0] mem_wdata_o, mem_rdata;
  logic [3:0] irq_o;

  int errs = 0, nchk = 0, wcnt = 0, rcnt = 0, ovl = 0, irqs = 0;
  bit finished = 1'b0;
  logic [31:0] mem [256];
  logic [AW-1:0] wlog [64];
  logic [AW-1:0] rlog [64];

  always #10 clk = ~clk;

  dmac_top #(.AW(AW), .CW(CW)) dut_i (
    .clk(clk), .rst(rst), .cfg_we_i(cfg_we), .cfg_ch_i(cfg_ch), .cfg_ofs_i(cfg_ofs),
    .cfg_wdata_i(cfg_wdata), .vblank_i(vblank), .hblank_i(hblank), .fifo_req_i(fifo_req),
    .fifo_addr_i(fifo_addr), .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o),
    .mem_size32_o(mem_size32_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .mem_rdata_i(mem_rdata), .cpu_stall_o(cpu_stall_o), .irq_o(irq_o));

  function automatic logic [31:0] pat(input int i);
    return {8'h5A, 4'h0, 12'(i), 8'(i * 7)};
  endfunction

  function automatic logic [31:0] ctl(input bit en, input bit ie, input int tm, input bit w,
                                      input bit rp, input int sa, input int da);
    return {16'h0, en, ie, 2'(tm), 1'b0, w, rp, 2'(sa), 2'(da), 5'b0};
  endfunction

  always @(posedge clk) begin
    if (mem_rd_o && mem_wr_o) ovl <= ovl + 1;
    if (|irq_o) irqs <= irqs + 1;
    if (mem_rd_o) begin
      rlog[rcnt % 64] <= mem_addr_o;
      rcnt <= rcnt + 1;
      if (mem_size32_o) mem_rdata <= mem[mem_addr_o[9:2]];
      else mem_rdata <= {16'h0, mem_addr_o[1] ? mem[mem_addr_o[9:2]][31:16] : mem[mem_addr_o[9:2]][15:0]};
    end
    if (mem_wr_o) begin
      wlog[wcnt % 64] <= mem_addr_o;
      wcnt <= wcnt + 1;
      if (mem_size32_o) mem[mem_addr_o[9:2]] <= mem_wdata_o;
      else if (mem_addr_o[1]) mem[mem_addr_o[9:2]][31:16] <= mem_wdata_o[15:0];
      else mem[mem_addr_o[9:2]][15:0] <= mem_wdata_o[15:0];
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input int ch, input logic [3:0] ofs, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_ch = 2'(ch); cfg_ofs = ofs; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic prog(input int ch, input int s, input int d, input int n, input logic [31:0] c);
    wr_reg(ch, 4'd10, 32'h0);
    wr_reg(ch, 4'd0, 32'(s));
    wr_reg(ch, 4'd4, 32'(d));
    wr_reg(ch, 4'd8, 32'(n));
    wr_reg(ch, 4'd10, c);
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    if (which == 0) vblank = 1'b1; else if (which == 1) hblank = 1'b1; else fifo_req = 1'b1;
    @(negedge clk);
    vblank = 1'b0; hblank = 1'b0; fifo_req = 1'b0;
  endtask

  task automatic wait_idle();
    int t = 0;
    while (cpu_stall_o && t < 2000) begin @(negedge clk); t++; end
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R10 stall after reset", cpu_stall_o, 0);
    chk("R12 irq after reset", irq_o, 0);
    chk("R13 bus idle after reset", {mem_rd_o, mem_wr_o}, 0);
  endtask

  task automatic t_immediate();
    int cyc = 0, first_wr = -1, b = wcnt;
    prog(0, 'h010, 'h200, 3, 32'h0);
    chk("R10 no stall before start", cpu_stall_o, 0);
    wr_reg(0, 4'd10, ctl(1, 1, 0, 1, 0, 0, 0));
    chk("R10 stall right after start", cpu_stall_o, 1);
    chk("R1 no read yet", mem_rd_o, 0);
    while (!irq_o[0] && cyc < 100) begin
      @(negedge clk); cyc++;
      if (cyc == 1) chk("R1 first read one cycle after start", mem_rd_o, 1);
      if (mem_wr_o && first_wr < 0) first_wr = cyc;
    end
    chk("R12 irq at 3n+1", cyc, 10);
    chk("R13 first write two cycles after read", first_wr, 3);
    @(negedge clk);
    chk("R12 irq lasts one cycle", irq_o, 0);
    chk("R10 stall drops after completion", cpu_stall_o, 0);
    chk("R13 element count", wcnt - b, 3);
    for (int k = 0; k < 3; k++) chk("R6 32-bit increment copy", mem['h80 + k], pat(4 + k));
  endtask

  task automatic t_addr_modes();
    logic [31:0] w41 = pat('h41), w40 = pat('h40);
    prog(3, 'h107, 'h301, 3, ctl(1, 0, 0, 0, 0, 1, 0));
    wait_idle();
    chk("R7 decrementing 16-bit source, aligned", mem['hC0], {w41[15:0], w41[31:16]});
    chk("R6 16-bit lane kept", mem['hC1][15:0], w40[31:16]);
    chk("R6 aligned halfword read address", rlog[(rcnt - 1) % 64], 'h102);
    prog(2, 'h020, 'h320, 2, ctl(1, 0, 0, 1, 0, 2, 0));
    wait_idle();
    chk("R7 fixed source first", mem['hC8], pat(8));
    chk("R7 fixed source second", mem['hC9], pat(8));
  endtask

  task automatic t_events();
    int b, ib;
    prog(1, 'h0C0, 'h240, 2, ctl(1, 0, 1, 1, 0, 0, 0));
    prog(2, 'h0E0, 'h260, 2, ctl(1, 0, 2, 1, 1, 0, 0));
    chk("R3 no pend without event", cpu_stall_o, 0);
    b = wcnt; ib = irqs;
    pulse(0); wait_idle();
    chk("R3 vblank moves only timing-1 channel", wcnt - b, 2);
    chk("R3 vblank data", mem['h91], pat('h31));
    b = wcnt;
    pulse(1); wait_idle();
    chk("R3 hblank moves timing-2 channel", wcnt - b, 2);
    chk("R3 hblank data", mem['h99], pat('h39));
    chk("R12 no irq when disabled", irqs - ib, 0);
    b = wcnt;
    @(negedge clk); vblank = 1'b1; @(negedge clk); vblank = 1'b0;
    chk("R11 finished channel ignores event", cpu_stall_o, 0);
    wait_idle();
    chk("R11 no transfer after non-repeat completion", wcnt - b, 0);
    b = wcnt;
    pulse(1); wait_idle();
    chk("R11 repeat restarts", wcnt - b, 2);
    chk("R11 repeat continues pointers", mem['h9B], pat('h3B));
  endtask

  task automatic t_order();
    int b = wcnt;
    prog(3, 'h010, 'h360, 1, ctl(1, 0, 1, 1, 0, 0, 0));
    prog(2, 'h010, 'h350, 1, ctl(1, 0, 1, 1, 0, 0, 0));
    prog(0, 'h010, 'h340, 1, ctl(1, 0, 1, 1, 0, 0, 0));
    pulse(0); wait_idle();
    chk("R9 three writes", wcnt - b, 3);
    chk("R9 channel 0 first", wlog[b % 64], 'h340);
    chk("R9 channel 2 second", wlog[(b + 1) % 64], 'h350);
    chk("R9 channel 3 last", wlog[(b + 2) % 64], 'h360);
  endtask

  task automatic t_cancel();
    int b;
    prog(3, 'h010, 'h3C0, 1, ctl(1, 0, 1, 1, 0, 0, 0));
    b = wcnt;
    wr_reg(0, 4'd0, 32'h0); wr_reg(0, 4'd4, 32'h380); wr_reg(0, 4'd8, 32'd8);
    wr_reg(0, 4'd10, ctl(1, 0, 0, 1, 0, 0, 0));
    pulse(0);
    wr_reg(3, 4'd10, ctl(1, 0, 1, 1, 0, 0, 0));
    wait_idle();
    chk("R2 cancelled channel made no writes", wcnt - b, 8);
    chk("R2 cancelled destination untouched", mem['hF0], pat('hF0));
    wr_reg(3, 4'd10, 32'h0);
  endtask

  task automatic t_fifo();
    int b;
    prog(1, 'h040, 'h3F0, 9, ctl(1, 0, 3, 0, 1, 1, 0));
    prog(0, 'h000, 'h3F0, 1, ctl(1, 0, 3, 1, 0, 0, 0));
    b = wcnt;
    fifo_addr = 'h3E0;
    @(negedge clk); fifo_req = 1'b1; @(negedge clk); fifo_req = 1'b0;
    chk("R4 address mismatch ignored", cpu_stall_o, 0);
    fifo_addr = 'h3F0;
    pulse(2); wait_idle();
    chk("R5 burst of four, channel 0 excluded", wcnt - b, 4);
    for (int k = 0; k < 4; k++) begin
      chk("R5 destination fixed", wlog[(b + k) % 64], 'h3F0);
      chk("R5 source +4", rlog[(rcnt - 4 + k) % 64], 32'('h40 + 4 * k));
    end
    chk("R5 last word", mem['hFC], pat('h13));
    b = wcnt;
    pulse(2); wait_idle();
    chk("R5 repeat burst", wcnt - b, 4);
    chk("R5 source continues", mem['hFC], pat('h17));
    wr_reg(1, 4'd10, 32'h0);
    wr_reg(0, 4'd10, 32'h0);
  endtask

  task automatic t_zero();
    int b = wcnt;
    prog(2, 'h100, 'h200, 0, ctl(1, 0, 0, 1, 0, 0, 0));
    wait_idle();
    chk("R8 zero count means 2^CW", wcnt - b, 16);
    chk("R8 last element", mem['h8F], pat('h4F));
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = pat(i);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_immediate();
    t_addr_modes();
    t_events();
    t_order();
    t_cancel();
    t_fifo();
    t_zero();
    chk("R13 read and write never overlap", ovl, 0);
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, nchk);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errs++; nchk++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errs, nchk);
      $finish;
    end
  end
endmodule